// File: doc/BRIEF.md
# Asynchronous SRAM Write Strobe Sequencer

This block turns single write requests into correctly ordered control waveforms for an asynchronous static RAM. A request carries an address, write data, a strobe-ordering mode and a flag saying whether the memory's output enable should be held active during the cycle. The controller accepts one request at a time through a valid/ready handshake. It then walks a fixed sequence of phases: address setup, strobe overlap, data hold and recovery. Every phase length is a clock-cycle count chosen at elaboration.

Two orderings are available. In write-enable-terminated mode (mode 0), chip select falls first and the write-enable pulse sits inside it. In chip-select-terminated mode (mode 1), write enable falls first and chip select is pulsed inside it, so the memory never drives the bus. When write-enable mode runs with output enable active, the memory may still be driving during the first part of the pulse. The controller then delays its own bus drive by the turn-off count and lengthens the pulse so that data is still set up in time. The tri-state data pad is represented by a drive-enable output next to the data output.

Top module: `sram_wr_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, mem_cs_n, mem_we_n and mem_oe_n are 1, mem_drive is 0 and req_ready is 1.
- R2: req_ready is 1 only while idle. A request is taken on a clock edge where req_valid and req_ready are both 1. req_ready is 0 from the next cycle until the sequence ends, and req_valid is ignored during that time.
- R3: mem_addr holds the accepted address from the first setup cycle until the next request is taken. It never changes while mem_cs_n and mem_we_n are both 0.
- R4: Mode 0 (write-enable terminated): mem_cs_n falls at the first setup cycle, and mem_we_n stays 1 for TAS cycles and then falls. After the pulse, both strobes rise on the same cycle, so write enable never rises while chip select is low.
- R5: Mode 1 (chip-select terminated): mem_we_n falls at the first setup cycle, and mem_cs_n falls TAS cycles later. After the pulse, mem_cs_n rises first and mem_we_n rises TDH cycles later.
- R6: The overlap in which both strobes are 0 lasts max(TWP, TWHZ+TDW) cycles in mode 0 when req_oe_low=1, and max(TWP, TDW) cycles otherwise.
- R7: mem_drive rises at overlap cycle TWHZ in mode 0 when req_oe_low=1, and at overlap cycle 0 otherwise. It stays 1 to the end of the overlap and for TDH cycles after it, and mem_dout equals the accepted data while mem_drive is 1.
- R8: mem_drive is never 1 while the memory could drive the bus, that is when mem_cs_n=0, mem_we_n=1 and mem_oe_n=0. It is 0 in setup, recovery and idle.
- R9: After the hold phase, all strobes are 1 and mem_drive is 0 for max(TWR, TWC−(TAS+overlap+TDH)) cycles before req_ready returns to 1. The span from setup to the end of recovery is therefore at least TWC cycles.
- R10: mem_oe_n equals the inverse of req_oe_low from setup through hold, and is 1 in recovery and idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_addr | input | AW | Write address |
| req_data | input | DW | Write data |
| req_mode | input | 1 | 0 = write-enable terminated, 1 = chip-select terminated |
| req_oe_low | input | 1 | 1 = hold the memory output enable active during the cycle |
| mem_addr | output | AW | Memory address pins |
| mem_dout | output | DW | Data presented to the bus pad |
| mem_drive | output | 1 | Bus pad drive enable |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |

## Verification
All four combinations of mode and output-enable flag are run as directed cases. They separate the pulse that is stretched by the turn-off count from the plain minimum pulse. They also separate the two strobe orderings and the delayed start of drive from the immediate start. A seeded random series mixes the combinations back to back with random addresses and data, which shows whether the latched per-request lengths follow each new request and do not carry over from the last one. One directed case keeps req_valid high and changes the address and data during a busy sequence, to show that the pins keep the captured values.

// File: rtl/sram_wr_pkg.sv
package sram_wr_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_PULSE = 3'd2,
    PH_HOLD  = 3'd3,
    PH_RECOV = 3'd4
  } phase_t;

  typedef struct packed {
    logic cs_n;
    logic we_n;
    logic oe_n;
    logic drive;
  } strobes_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_wr_timing.sv
// Per-request phase lengths, derived from the request's mode and OE flag.
module sram_wr_timing #(
  parameter int TAS  = 2,
  parameter int TWP  = 3,
  parameter int TDW  = 2,
  parameter int TDH  = 1,
  parameter int TWR  = 2,
  parameter int TWHZ = 2,
  parameter int TWC  = 12,
  parameter int CW   = 6
) (
  input  logic          mode_cs,
  input  logic          oe_low,
  output logic [CW-1:0] pulse_len,
  output logic [CW-1:0] recov_len,
  output logic [CW-1:0] drive_ofs
);
  import sram_wr_pkg::*;

  int ofs_i;
  int pul_i;
  int rec_i;
  int busy_i;

  always_comb begin
    ofs_i  = (!mode_cs && oe_low) ? TWHZ : 0;
    pul_i  = imax(TWP, ofs_i + TDW);
    busy_i = TAS + pul_i + TDH;
    rec_i  = imax(TWR, TWC - busy_i);
  end

  assign pulse_len = CW'(pul_i);
  assign recov_len = CW'(rec_i);
  assign drive_ofs = CW'(ofs_i);

endmodule

// File: rtl/sram_wr_fsm.sv
// Phase sequencer: owns the request latches and the phase counter and
// exposes next-cycle values so the output stage can register them.
module sram_wr_fsm #(
  parameter int AW  = 16,
  parameter int DW  = 16,
  parameter int TAS = 2,
  parameter int TDH = 1,
  parameter int CW  = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic [AW-1:0]        req_addr,
  input  logic [DW-1:0]        req_data,
  input  logic                 req_mode,
  input  logic                 req_oe_low,
  input  logic [CW-1:0]        req_pulse_len,
  input  logic [CW-1:0]        req_recov_len,
  input  logic [CW-1:0]        req_drive_ofs,
  output sram_wr_pkg::phase_t  nx_phase,
  output logic [CW-1:0]        nx_cnt,
  output logic                 nx_mode,
  output logic                 nx_oe,
  output logic [CW-1:0]        nx_ofs,
  output logic [AW-1:0]        nx_addr,
  output logic [DW-1:0]        nx_data
);
  import sram_wr_pkg::*;

  localparam logic [CW-1:0] SETUP_LAST = CW'(TAS - 1);
  localparam logic [CW-1:0] HOLD_LAST  = CW'(TDH - 1);
  localparam logic [CW-1:0] ONE        = CW'(1);

  phase_t        phase_q;
  logic [CW-1:0] cnt_q;
  logic          mode_q;
  logic          oe_q;
  logic [CW-1:0] pul_q;
  logic [CW-1:0] rec_q;
  logic [CW-1:0] ofs_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  logic          take;
  logic          last;
  logic [CW-1:0] nx_pul;
  logic [CW-1:0] nx_rec;

  assign take = (phase_q == PH_IDLE) && req_valid;

  always_comb begin
    unique case (phase_q)
      PH_SETUP: last = (cnt_q == SETUP_LAST);
      PH_PULSE: last = (cnt_q == pul_q - ONE);
      PH_HOLD:  last = (cnt_q == HOLD_LAST);
      PH_RECOV: last = (cnt_q == rec_q - ONE);
      default:  last = 1'b0;
    endcase
  end

  always_comb begin
    nx_phase = phase_q;
    unique case (phase_q)
      PH_IDLE:  if (take) nx_phase = PH_SETUP;
      PH_SETUP: if (last) nx_phase = PH_PULSE;
      PH_PULSE: if (last) nx_phase = PH_HOLD;
      PH_HOLD:  if (last) nx_phase = PH_RECOV;
      PH_RECOV: if (last) nx_phase = PH_IDLE;
      default:  nx_phase = PH_IDLE;
    endcase
    nx_cnt = (nx_phase != phase_q) ? '0 : cnt_q + ONE;
    if (nx_phase == PH_IDLE) nx_cnt = '0;
  end

  assign nx_mode = take ? req_mode      : mode_q;
  assign nx_oe   = take ? req_oe_low    : oe_q;
  assign nx_ofs  = take ? req_drive_ofs : ofs_q;
  assign nx_pul  = take ? req_pulse_len : pul_q;
  assign nx_rec  = take ? req_recov_len : rec_q;
  assign nx_addr = take ? req_addr      : addr_q;
  assign nx_data = take ? req_data      : data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      mode_q  <= 1'b0;
      oe_q    <= 1'b0;
      pul_q   <= ONE;
      rec_q   <= ONE;
      ofs_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      phase_q <= nx_phase;
      cnt_q   <= nx_cnt;
      mode_q  <= nx_mode;
      oe_q    <= nx_oe;
      pul_q   <= nx_pul;
      rec_q   <= nx_rec;
      ofs_q   <= nx_ofs;
      addr_q  <= nx_addr;
      data_q  <= nx_data;
    end
  end

endmodule

// File: rtl/sram_wr_pins.sv
// Decodes the next phase into strobe levels and registers every pin.
module sram_wr_pins #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  sram_wr_pkg::phase_t nx_phase,
  input  logic [CW-1:0]       nx_cnt,
  input  logic                nx_mode,
  input  logic                nx_oe,
  input  logic [CW-1:0]       nx_ofs,
  input  logic [AW-1:0]       nx_addr,
  input  logic [DW-1:0]       nx_data,
  output logic                ready,
  output logic [AW-1:0]       pin_addr,
  output logic [DW-1:0]       pin_dout,
  output logic                pin_drive,
  output logic                pin_cs_n,
  output logic                pin_we_n,
  output logic                pin_oe_n
);
  import sram_wr_pkg::*;

  strobes_t dec;

  always_comb begin
    dec = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, drive: 1'b0};
    unique case (nx_phase)
      PH_SETUP: begin
        dec.cs_n = nx_mode;
        dec.we_n = !nx_mode;
        dec.oe_n = !nx_oe;
      end
      PH_PULSE: begin
        dec.cs_n  = 1'b0;
        dec.we_n  = 1'b0;
        dec.oe_n  = !nx_oe;
        dec.drive = (nx_cnt >= nx_ofs);
      end
      PH_HOLD: begin
        dec.cs_n  = 1'b1;
        dec.we_n  = !nx_mode;
        dec.oe_n  = !nx_oe;
        dec.drive = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ready     <= 1'b1;
      pin_addr  <= '0;
      pin_dout  <= '0;
      pin_drive <= 1'b0;
      pin_cs_n  <= 1'b1;
      pin_we_n  <= 1'b1;
      pin_oe_n  <= 1'b1;
    end else begin
      ready     <= (nx_phase == PH_IDLE);
      pin_addr  <= nx_addr;
      pin_dout  <= nx_data;
      pin_drive <= dec.drive;
      pin_cs_n  <= dec.cs_n;
      pin_we_n  <= dec.we_n;
      pin_oe_n  <= dec.oe_n;
    end
  end

endmodule

// File: rtl/sram_wr_seq.sv
module sram_wr_seq #(
  parameter int AW   = 16,
  parameter int DW   = 16,
  parameter int TAS  = 2,
  parameter int TWP  = 3,
  parameter int TDW  = 2,
  parameter int TDH  = 1,
  parameter int TWR  = 2,
  parameter int TWHZ = 2,
  parameter int TWC  = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          req_mode,
  input  logic          req_oe_low,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dout,
  output logic          mem_drive,
  output logic          mem_cs_n,
  output logic          mem_we_n,
  output logic          mem_oe_n
);
  import sram_wr_pkg::*;

  localparam int LEN_MAX = TWC + TAS + TWP + TWHZ + TDW + TDH + TWR;
  localparam int CW      = $clog2(LEN_MAX + 1) + 1;

  logic [CW-1:0] t_pul;
  logic [CW-1:0] t_rec;
  logic [CW-1:0] t_ofs;
  phase_t        nx_phase;
  logic [CW-1:0] nx_cnt;
  logic          nx_mode;
  logic          nx_oe;
  logic [CW-1:0] nx_ofs;
  logic [AW-1:0] nx_addr;
  logic [DW-1:0] nx_data;

  sram_wr_timing #(
    .TAS(TAS), .TWP(TWP), .TDW(TDW), .TDH(TDH),
    .TWR(TWR), .TWHZ(TWHZ), .TWC(TWC), .CW(CW)
  ) u_timing (
    .mode_cs   (req_mode),
    .oe_low    (req_oe_low),
    .pulse_len (t_pul),
    .recov_len (t_rec),
    .drive_ofs (t_ofs)
  );

  sram_wr_fsm #(
    .AW(AW), .DW(DW), .TAS(TAS), .TDH(TDH), .CW(CW)
  ) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_addr      (req_addr),
    .req_data      (req_data),
    .req_mode      (req_mode),
    .req_oe_low    (req_oe_low),
    .req_pulse_len (t_pul),
    .req_recov_len (t_rec),
    .req_drive_ofs (t_ofs),
    .nx_phase      (nx_phase),
    .nx_cnt        (nx_cnt),
    .nx_mode       (nx_mode),
    .nx_oe         (nx_oe),
    .nx_ofs        (nx_ofs),
    .nx_addr       (nx_addr),
    .nx_data       (nx_data)
  );

  sram_wr_pins #(
    .AW(AW), .DW(DW), .CW(CW)
  ) u_pins (
    .clk       (clk),
    .rst       (rst),
    .nx_phase  (nx_phase),
    .nx_cnt    (nx_cnt),
    .nx_mode   (nx_mode),
    .nx_oe     (nx_oe),
    .nx_ofs    (nx_ofs),
    .nx_addr   (nx_addr),
    .nx_data   (nx_data),
    .ready     (req_ready),
    .pin_addr  (mem_addr),
    .pin_dout  (mem_dout),
    .pin_drive (mem_drive),
    .pin_cs_n  (mem_cs_n),
    .pin_we_n  (mem_we_n),
    .pin_oe_n  (mem_oe_n)
  );

endmodule

// File: rtl/sram_wr_seq_chk.sv
module sram_wr_seq_chk #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_dout,
  input logic          mem_drive,
  input logic          mem_cs_n,
  input logic          mem_we_n,
  input logic          mem_oe_n
);

  p_ready_idle_r2: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_cs_n && mem_we_n && !mem_drive));

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  p_addr_stable_r3: assert property (@(posedge clk) disable iff (rst)
    (!mem_cs_n && !mem_we_n && $past(!mem_cs_n && !mem_we_n)) |-> $stable(mem_addr));

  p_we_rise_cs_high_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> mem_cs_n);

  p_data_stable_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_drive && $past(mem_drive)) |-> $stable(mem_dout));

  p_no_contention_r8: assert property (@(posedge clk) disable iff (rst)
    mem_drive |-> !(!mem_cs_n && mem_we_n && !mem_oe_n));

  p_oe_idle_r10: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> mem_oe_n);

endmodule

bind sram_wr_seq sram_wr_seq_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .mem_addr  (mem_addr),
  .mem_dout  (mem_dout),
  .mem_drive (mem_drive),
  .mem_cs_n  (mem_cs_n),
  .mem_we_n  (mem_we_n),
  .mem_oe_n  (mem_oe_n)
);

// File: tb/sram_wr_seq_test.sv
`timescale 1ns/1ps
module sram_wr_seq_test;
  localparam int AW = 16, DW = 16;
  localparam int TAS = 2, TWP = 3, TDW = 2, TDH = 1, TWR = 2, TWHZ = 2, TWC = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic req_mode = 1'b0;
  logic req_oe_low = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dout;
  logic mem_drive, mem_cs_n, mem_we_n, mem_oe_n;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sram_wr_seq #(.AW(AW), .DW(DW), .TAS(TAS), .TWP(TWP), .TDW(TDW), .TDH(TDH),
                .TWR(TWR), .TWHZ(TWHZ), .TWC(TWC)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_mode(req_mode),
    .req_oe_low(req_oe_low), .mem_addr(mem_addr), .mem_dout(mem_dout),
    .mem_drive(mem_drive), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n));

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int e_ofs(input bit m, input bit o);
    return (!m && o) ? TWHZ : 0;
  endfunction

  // R6 overlap length
  function automatic int e_pulse(input bit m, input bit o);
    return mx(TWP, e_ofs(m, o) + TDW);
  endfunction

  // R9 recovery length
  function automatic int e_recov(input bit m, input bit o);
    return mx(TWR, TWC - (TAS + e_pulse(m, o) + TDH));
  endfunction

  function automatic int e_span(input bit m, input bit o);
    return TAS + e_pulse(m, o) + TDH + e_recov(m, o);
  endfunction

  // expected {cs_n, we_n, oe_n, drive} at cycle k of a sequence
  function automatic logic [3:0] e_pins(input bit m, input bit o, input int k);
    int p;
    p = e_pulse(m, o);
    if (k < TAS)                return {m, !m, !o, 1'b0};
    else if (k < TAS + p)       return {2'b00, !o, (k - TAS) >= e_ofs(m, o)};
    else if (k < TAS + p + TDH) return {1'b1, !m, !o, 1'b1};
    else                        return 4'b1110;
  endfunction

  function automatic string rtag(input bit m, input bit o, input int k);
    int p;
    p = e_pulse(m, o);
    if (k < TAS)                return m ? "R5/R10" : "R4/R10";
    else if (k < TAS + p)       return "R6/R7/R8";
    else if (k < TAS + p + TDH) return m ? "R5/R7" : "R4/R7";
    else                        return "R9";
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_txn(input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input bit m, input bit o, input bit junk);
    int span;
    logic [3:0] ep;
    logic [3:0] ap;
    span = e_span(m, o);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_data = d; req_mode = m; req_oe_low = o;
    @(negedge clk);
    if (junk) begin
      req_addr = ~a; req_data = ~d; req_mode = !m; req_oe_low = !o;
    end else req_valid = 1'b0;
    for (int k = 0; k < span; k++) begin
      ep = e_pins(m, o, k);
      ap = {mem_cs_n, mem_we_n, mem_oe_n, mem_drive};
      chk(ap == ep, rtag(m, o, k), $sformatf("pins cycle %0d", k), ap, ep);
      chk(req_ready == 1'b0, "R2", "ready while busy", req_ready, 0);
      chk(mem_addr == a, "R3", "address held", mem_addr, a);
      if (mem_drive) chk(mem_dout == d, "R7", "data while driving", mem_dout, d);
      if (k == span - 1) req_valid = 1'b0;
      @(negedge clk);
    end
    chk(req_ready == 1'b1, "R9", "ready after recovery", req_ready, 1);
    ap = {mem_cs_n, mem_we_n, mem_oe_n, mem_drive};
    chk(ap == 4'b1110, "R8", "idle pins", ap, 4'b1110);
    chk(mem_addr == a, "R3", "address kept in idle", mem_addr, a);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    logic [3:0] ap;
    seed = 32'd1234;
    repeat (3) @(negedge clk);
    ap = {mem_cs_n, mem_we_n, mem_oe_n, mem_drive};
    chk(ap == 4'b1110, "R1", "pins in reset", ap, 4'b1110);
    chk(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
    rst = 1'b0;
    @(negedge clk);
    ap = {mem_cs_n, mem_we_n, mem_oe_n, mem_drive};
    chk(ap == 4'b1110, "R1", "pins after reset", ap, 4'b1110);
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);

    run_txn(16'h1234, 16'hA5A5, 1'b0, 1'b1, 1'b0);  // stretched pulse
    run_txn(16'h2345, 16'h5A5A, 1'b0, 1'b0, 1'b0);  // plain WE pulse
    run_txn(16'h3456, 16'hC3C3, 1'b1, 1'b1, 1'b0);  // CS terminated, OE low
    run_txn(16'h4567, 16'h3C3C, 1'b1, 1'b0, 1'b0);  // CS terminated
    run_txn(16'hFFFF, 16'h0000, 1'b0, 1'b1, 1'b1);  // R2: valid held, inputs change
    run_txn(16'h0000, 16'hFFFF, 1'b1, 1'b0, 1'b1);

    for (int i = 0; i < 40; i++) begin
      logic [AW-1:0] ra;
      logic [DW-1:0] rd;
      bit rm, ro;
      ra = AW'($urandom(seed)); seed = seed + 32'd7919;
      rd = DW'($urandom(seed)); seed = seed + 32'd104729;
      rm = ra[0] ^ rd[3];
      ro = ra[5] ^ rd[1];
      run_txn(ra, rd, rm, ro, rd[7]);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule